// File: doc/BRIEF.md
# DMA Request Arbiter with Channel Notification

This block decides which of eight DMA channels may start its next transfer and then tells an external device which channel won. Each channel picks one of three request sources: an internal automatic request, an external request line, or a request from an on-chip peripheral. A request counts only when the channel is allowed to transfer. The channel must be enabled and not blocked by its own transfer-end or address-error flag. The global master enable must be set and the NMI flag must be clear. Among the eligible requests, fixed priority picks a single channel.

Two operating styles exist. In normal mode all eight channels are live, but only the two lowest channels may take requests from external lines. In on-demand mode a width select makes either four or eight channels live, and every live channel may take external requests. The winning channel is captured into a held one-hot grant. A single-cycle acknowledge pulse goes out together with the channel number. In eight-channel on-demand mode, the third channel-number bit borrows the bus-release pin for the acknowledge cycle only.

The grant is held until the surrounding transfer engine reports completion, or until the channel loses its right to transfer. Address generation, counting and bus timing belong to other blocks.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is high, and on the first cycle after it, `grant` is zero, `xfer_ack` is 0 and `chan_id` is 0, whatever requests are present.
- R2: A channel is eligible only when `ch_en` is 1, `master_en` is 1, its `ch_te` is 0, `nmi_flag` is 0 and its `ch_ae` is 0. Clearing any one of these prevents a grant.
- R3: When several channels are eligible at once, the lowest channel number wins. Channel 0 has the highest priority and channel 7 the lowest.
- R4: Each channel has a two-bit source code in `src_sel[2*n+1:2*n]`: 0 selects `auto_req[n]`, 1 selects `ext_req[n]`, 2 selects `periph_req[n]`, and 3 selects no source. The lines that are not selected have no effect.
- R5: In normal mode (`ondemand`=0) all eight channels can be granted, but an external request is accepted only on channels 0 and 1. An external request on any other channel never produces a grant.
- R6: In on-demand mode with `eight_ch`=0, only channels 0 to 3 are live and all four accept external requests. Channels 4 to 7 are never granted.
- R7: In on-demand mode with `eight_ch`=1, all eight channels are live and all accept external requests.
- R8: A grant is captured at the clock edge after which a request is seen eligible while no grant is held. `xfer_ack` is high for exactly that one following cycle. The one-hot `grant` then stays unchanged, with no further acknowledge, until it is released.
- R9: `chan_id` carries bits 1:0 of the granted channel number during the acknowledge cycle and reads 0 in every other cycle.
- R10: In on-demand eight-channel mode, `brel_pin` carries bit 2 of the granted channel number during the acknowledge cycle. In every other cycle and every other mode it follows `bus_rel_in`.
- R11: If `nmi_flag` rises, `master_en` falls, or the granted channel's own enable or error flags block it, the grant drops at the next edge. No acknowledge is issued while the condition stays.
- R12: `xfer_done` high while a grant is held clears the grant at the next edge. A new arbitration can capture a grant no earlier than the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | 8 | Per-channel enable |
| ch_te | input | 8 | Per-channel transfer-end flag |
| ch_ae | input | 8 | Per-channel address-error flag |
| master_en | input | 1 | Global DMA master enable |
| nmi_flag | input | 1 | Non-maskable interrupt flag, blocks all channels |
| ondemand | input | 1 | 0 = normal mode, 1 = on-demand mode |
| eight_ch | input | 1 | On-demand width select: 0 = four channels, 1 = eight |
| src_sel | input | 16 | Two-bit request source code per channel |
| auto_req | input | 8 | Automatic request per channel |
| ext_req | input | 8 | External request line per channel |
| periph_req | input | 8 | On-chip peripheral request per channel |
| xfer_done | input | 1 | Granted transfer has been served |
| bus_rel_in | input | 1 | Bus-release notification value to present on the shared pin |
| grant | output | 8 | One-hot held grant |
| xfer_ack | output | 1 | Single-cycle transfer acknowledge |
| chan_id | output | 2 | Low bits of granted channel, valid with acknowledge |
| brel_pin | output | 1 | Shared pin: bus-release notification or channel bit 2 |

## Verification
A wrong mode mask or gating term shows up one edge after stimulus: a grant either appears or stays absent on the wrong channel, and `xfer_ack` pulses or does not. A corrupted held grant or index is visible on the very next cycle, either as a repeated or stretched acknowledge or as a wrong `chan_id`/`brel_pin` value during the pulse. A release fault, where the grant survives `xfer_done` or an NMI, shows as a grant still present one edge after the event. A missing re-arbitration shows the edge after that.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;

    localparam int unsigned NCH           = 8;
    localparam int unsigned IDW           = $clog2(NCH);
    localparam int unsigned ID_LO_W       = 2;
    localparam int unsigned SRC_W         = 2;
    localparam int unsigned NORMAL_EXT_CH = 2;
    localparam int unsigned OD_NARROW_CH  = 4;

    typedef enum logic [SRC_W-1:0] {
        SRC_AUTO   = 2'd0,
        SRC_EXT    = 2'd1,
        SRC_PERIPH = 2'd2,
        SRC_NONE   = 2'd3
    } src_kind_e;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_OD4    = 2'd1,
        MODE_OD8    = 2'd2
    } arb_mode_e;

    typedef struct packed {
        logic           valid;
        logic [IDW-1:0] idx;
    } pick_t;

    function automatic logic [NCH-1:0] low_mask(input int unsigned n);
        logic [NCH-1:0] m;
        for (int unsigned i = 0; i < NCH; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

    function automatic logic [NCH-1:0] to_onehot(input logic [IDW-1:0] idx);
        logic [NCH-1:0] m;
        m      = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

    function automatic arb_mode_e decode_mode(input logic od, input logic wide);
        if (!od)       return MODE_NORMAL;
        else if (wide) return MODE_OD8;
        else           return MODE_OD4;
    endfunction

    function automatic logic [NCH-1:0] live_mask(input arb_mode_e mode);
        case (mode)
            MODE_OD4: return low_mask(OD_NARROW_CH);
            default:  return low_mask(NCH);
        endcase
    endfunction

    function automatic logic [NCH-1:0] ext_mask(input arb_mode_e mode);
        case (mode)
            MODE_NORMAL: return low_mask(NORMAL_EXT_CH);
            MODE_OD4:    return low_mask(OD_NARROW_CH);
            MODE_OD8:    return low_mask(NCH);
            default:     return '0;
        endcase
    endfunction

endpackage

// File: rtl/dmaarb_gate.sv
module dmaarb_gate
    import dmaarb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  arb_mode_e       mode,
    input  logic [NCH-1:0]  ch_en,
    input  logic [NCH-1:0]  ch_te,
    input  logic [NCH-1:0]  ch_ae,
    input  logic            master_en,
    input  logic            nmi_flag,
    input  src_kind_e       src_kind [NCH],
    input  logic [NCH-1:0]  auto_req,
    input  logic [NCH-1:0]  ext_req,
    input  logic [NCH-1:0]  periph_req,
    output logic [NCH-1:0]  chan_ok,
    output logic [NCH-1:0]  eligible
);

    logic [NCH-1:0] live;
    logic [NCH-1:0] ext_ok;
    logic           global_ok;

    assign live      = live_mask(mode);
    assign ext_ok    = ext_mask(mode);
    assign global_ok = master_en & ~nmi_flag;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic req_sel;

        always_comb begin
            case (src_kind[i])
                SRC_AUTO:   req_sel = auto_req[i];
                SRC_EXT:    req_sel = ext_req[i] & ext_ok[i];
                SRC_PERIPH: req_sel = periph_req[i];
                default:    req_sel = 1'b0;
            endcase
        end

        assign chan_ok[i]  = global_ok & ch_en[i] & ~ch_te[i] & ~ch_ae[i] & live[i];
        assign eligible[i] = chan_ok[i] & req_sel;

        AST_DEAD_CH_QUIET: assert property (@(posedge clk) disable iff (rst)
            (mode == MODE_OD4 && i >= OD_NARROW_CH) |-> !eligible[i]); // R6

        AST_NORMAL_EXT_BLOCK: assert property (@(posedge clk) disable iff (rst)
            (mode == MODE_NORMAL && i >= NORMAL_EXT_CH && src_kind[i] == SRC_EXT) |-> !eligible[i]); // R5

        AST_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (rst)
            (nmi_flag || !master_en || !ch_en[i] || ch_te[i] || ch_ae[i]) |-> !eligible[i]); // R2
    end

endmodule

// File: rtl/dmaarb_prio.sv
module dmaarb_prio
    import dmaarb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NCH-1:0]  req,
    output pick_t           pick
);

    always_comb begin
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick.valid = 1'b1;
                pick.idx   = IDW'(i);
            end
        end
    end

    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (rst)
        pick.valid |-> ((req & low_mask(int'(pick.idx))) == '0) && req[pick.idx]); // R3

    AST_PICK_VALID: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |-> pick.valid); // R3

endmodule

// File: rtl/dmaarb_ctrl.sv
module dmaarb_ctrl
    import dmaarb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  arb_mode_e          mode,
    input  logic [NCH-1:0]     chan_ok,
    input  pick_t              pick,
    input  logic               xfer_done,
    input  logic               bus_rel_in,
    output logic [NCH-1:0]     grant,
    output logic               xfer_ack,
    output logic [ID_LO_W-1:0] chan_id,
    output logic               brel_pin
);

    logic [NCH-1:0] grant_q;
    logic           ack_q;
    logic [IDW-1:0] idx_q;
    logic           holding;
    logic           still_ok;

    assign holding  = (grant_q != '0);
    assign still_ok = ((grant_q & chan_ok) != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
            ack_q   <= 1'b0;
            idx_q   <= '0;
        end else begin
            ack_q <= 1'b0;
            if (holding) begin
                if (xfer_done || !still_ok) begin
                    grant_q <= '0;
                end
            end else if (pick.valid) begin
                grant_q <= to_onehot(pick.idx);
                ack_q   <= 1'b1;
                idx_q   <= pick.idx;
            end
        end
    end

    assign grant    = grant_q;
    assign xfer_ack = ack_q;
    assign chan_id  = ack_q ? idx_q[ID_LO_W-1:0] : '0;
    assign brel_pin = (ack_q && mode == MODE_OD8) ? idx_q[IDW-1] : bus_rel_in;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_q)); // R8

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ack_q |=> !ack_q); // R8

    AST_ACK_HAS_GRANT: assert property (@(posedge clk) disable iff (rst)
        ack_q |-> $onehot(grant_q)); // R8

    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (holding && !xfer_done && still_ok) |=> $stable(grant_q) && !ack_q); // R8

    AST_GATE_DROP: assert property (@(posedge clk) disable iff (rst)
        (holding && !still_ok) |=> (grant_q == '0) && !ack_q); // R11

    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (holding && xfer_done) |=> (grant_q == '0) && !ack_q); // R12

    AST_NEW_GRANT_ACK: assert property (@(posedge clk) disable iff (rst)
        (!holding && pick.valid) |=> ack_q); // R8

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dmaarb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NCH-1:0]     ch_en,
    input  logic [NCH-1:0]     ch_te,
    input  logic [NCH-1:0]     ch_ae,
    input  logic               master_en,
    input  logic               nmi_flag,
    input  logic               ondemand,
    input  logic               eight_ch,
    input  logic [SRC_W*NCH-1:0] src_sel,
    input  logic [NCH-1:0]     auto_req,
    input  logic [NCH-1:0]     ext_req,
    input  logic [NCH-1:0]     periph_req,
    input  logic               xfer_done,
    input  logic               bus_rel_in,
    output logic [NCH-1:0]     grant,
    output logic               xfer_ack,
    output logic [ID_LO_W-1:0] chan_id,
    output logic               brel_pin
);

    arb_mode_e      mode;
    src_kind_e      src_kind [NCH];
    logic [NCH-1:0] chan_ok;
    logic [NCH-1:0] eligible;
    pick_t          pick;

    assign mode = decode_mode(ondemand, eight_ch);

    for (genvar i = 0; i < NCH; i++) begin : g_src
        assign src_kind[i] = src_kind_e'(src_sel[SRC_W*i +: SRC_W]);
    end

    dmaarb_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .ch_en      (ch_en),
        .ch_te      (ch_te),
        .ch_ae      (ch_ae),
        .master_en  (master_en),
        .nmi_flag   (nmi_flag),
        .src_kind   (src_kind),
        .auto_req   (auto_req),
        .ext_req    (ext_req),
        .periph_req (periph_req),
        .chan_ok    (chan_ok),
        .eligible   (eligible)
    );

    dmaarb_prio u_prio (
        .clk  (clk),
        .rst  (rst),
        .req  (eligible),
        .pick (pick)
    );

    dmaarb_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .chan_ok    (chan_ok),
        .pick       (pick),
        .xfer_done  (xfer_done),
        .bus_rel_in (bus_rel_in),
        .grant      (grant),
        .xfer_ack   (xfer_ack),
        .chan_id    (chan_id),
        .brel_pin   (brel_pin)
    );

    AST_ID_LOW_MATCH: assert property (@(posedge clk) disable iff (rst)
        xfer_ack |-> grant[{1'b0, chan_id}] || grant[{1'b1, chan_id}]); // R9

    AST_ID_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !xfer_ack |-> (chan_id == '0)); // R9

    AST_PIN_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        (!xfer_ack || !ondemand || !eight_ch) |-> (brel_pin == bus_rel_in)); // R10

    AST_NMI_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (nmi_flag || !master_en) |=> !xfer_ack && (grant == '0)); // R11

endmodule

// File: tb/dma_req_arbiter_bench.sv
`timescale 1ns/1ps
module dma_req_arbiter_bench;
    import dmaarb_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  ch_en, ch_te, ch_ae;
    logic        master_en, nmi_flag, ondemand, eight_ch;
    logic [15:0] src_sel;
    logic [7:0]  auto_req, ext_req, periph_req;
    logic        xfer_done, bus_rel_in;
    logic [7:0]  grant;
    logic        xfer_ack;
    logic [1:0]  chan_id;
    logic        brel_pin;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dma_req_arbiter u_dma_req_arbiter (
        .clk(clk), .rst(rst), .ch_en(ch_en), .ch_te(ch_te), .ch_ae(ch_ae),
        .master_en(master_en), .nmi_flag(nmi_flag), .ondemand(ondemand),
        .eight_ch(eight_ch), .src_sel(src_sel), .auto_req(auto_req),
        .ext_req(ext_req), .periph_req(periph_req), .xfer_done(xfer_done),
        .bus_rel_in(bus_rel_in), .grant(grant), .xfer_ack(xfer_ack),
        .chan_id(chan_id), .brel_pin(brel_pin)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic defaults();
        ch_en = 8'hFF; ch_te = '0; ch_ae = '0;
        master_en = 1'b1; nmi_flag = 1'b0; ondemand = 1'b0; eight_ch = 1'b0;
        src_sel = '0; auto_req = '0; ext_req = '0; periph_req = '0;
        xfer_done = 1'b0; bus_rel_in = 1'b0;
    endtask

    task automatic set_src(input int ch, input logic [1:0] code);
        src_sel[2*ch +: 2] = code;
    endtask

    task automatic expect_ack(input int ch, input string rq);
        step();
        check(grant == 8'(1 << ch), rq, "grant", grant, 1 << ch);
        check(xfer_ack == 1'b1, rq, "ack", xfer_ack, 1);
        check(chan_id == 2'(ch), rq, "chan_id", chan_id, ch & 3);
    endtask

    task automatic expect_none(input int n, input string rq);
        for (int k = 0; k < n; k++) begin
            step();
            check(grant == '0 && !xfer_ack, rq, "idle grant", grant, 0);
        end
    endtask

    task automatic release_grant(input string rq);
        auto_req = '0; ext_req = '0; periph_req = '0;
        xfer_done = 1'b1;
        step();
        check(grant == '0, rq, "released", grant, 0);
        xfer_done = 1'b0;
        step();
    endtask

    task automatic t_reset();
        defaults();
        rst = 1'b1;
        auto_req = 8'hFF;
        repeat (3) step();
        check(grant == '0, "R1", "grant in reset", grant, 0);
        check(xfer_ack == 1'b0, "R1", "ack in reset", xfer_ack, 0);
        check(chan_id == '0, "R1", "id in reset", chan_id, 0);
        auto_req = '0;
        rst = 1'b0;
        step();
        check(grant == '0 && !xfer_ack, "R1", "after reset", grant, 0);
    endtask

    task automatic t_gating();
        for (int c = 0; c < 5; c++) begin
            defaults();
            case (c)
                0: ch_en[0] = 1'b0;
                1: ch_te[0] = 1'b1;
                2: ch_ae[0] = 1'b1;
                3: master_en = 1'b0;
                default: nmi_flag = 1'b1;
            endcase
            auto_req[0] = 1'b1;
            expect_none(2, "R2");
        end
        defaults();
        auto_req[0] = 1'b1;
        expect_ack(0, "R2");
        release_grant("R12");
    endtask

    task automatic t_priority();
        defaults();
        ondemand = 1'b1; eight_ch = 1'b1; bus_rel_in = 1'b1;
        auto_req = 8'b0010_0100;
        expect_ack(2, "R3");
        check(brel_pin == 1'b0, "R10", "pin bit2 of ch2", brel_pin, 0);
        step();
        check(xfer_ack == 1'b0, "R8", "ack single", xfer_ack, 0);
        check(chan_id == '0, "R9", "id idle", chan_id, 0);
        check(brel_pin == 1'b1, "R10", "pin passthru", brel_pin, 1);
        for (int k = 0; k < 3; k++) begin
            step();
            check(grant == 8'h04 && !xfer_ack, "R8", "held", grant, 4);
        end
        auto_req = 8'b0010_0000;
        xfer_done = 1'b1;
        step();
        check(grant == '0, "R12", "cleared on done", grant, 0);
        xfer_done = 1'b0;
        bus_rel_in = 1'b0;
        expect_ack(5, "R3");
        check(brel_pin == 1'b1, "R10", "pin bit2 of ch5", brel_pin, 1);
        release_grant("R12");
    endtask

    task automatic t_source();
        defaults();
        set_src(3, SRC_PERIPH);
        auto_req[3] = 1'b1; ext_req[3] = 1'b1;
        expect_none(2, "R4");
        periph_req[3] = 1'b1;
        expect_ack(3, "R4");
        release_grant("R4");
        set_src(3, SRC_NONE);
        auto_req[3] = 1'b1; ext_req[3] = 1'b1; periph_req[3] = 1'b1;
        expect_none(2, "R4");
    endtask

    task automatic t_normal();
        defaults();
        set_src(2, SRC_EXT);
        ext_req[2] = 1'b1;
        expect_none(2, "R5");
        set_src(1, SRC_EXT);
        ext_req[1] = 1'b1;
        expect_ack(1, "R5");
        release_grant("R5");
        defaults();
        auto_req[7] = 1'b1;
        expect_ack(7, "R5");
        check(brel_pin == 1'b0, "R10", "normal mode pin", brel_pin, 0);
        release_grant("R5");
    endtask

    task automatic t_od4();
        defaults();
        ondemand = 1'b1; eight_ch = 1'b0;
        auto_req[5] = 1'b1;
        expect_none(2, "R6");
        set_src(3, SRC_EXT);
        ext_req[3] = 1'b1;
        expect_ack(3, "R6");
        check(brel_pin == 1'b0, "R10", "four-ch pin", brel_pin, 0);
        release_grant("R6");
    endtask

    task automatic t_od8();
        defaults();
        ondemand = 1'b1; eight_ch = 1'b1;
        set_src(6, SRC_EXT);
        ext_req[6] = 1'b1;
        expect_ack(6, "R7");
        check(brel_pin == 1'b1, "R10", "pin bit2 of ch6", brel_pin, 1);
        step();
        check(brel_pin == 1'b0, "R10", "pin back", brel_pin, 0);
        release_grant("R7");
    endtask

    task automatic t_nmi();
        defaults();
        auto_req[0] = 1'b1;
        expect_ack(0, "R11");
        step();
        check(grant == 8'h01, "R8", "held before nmi", grant, 1);
        nmi_flag = 1'b1;
        step();
        check(grant == '0, "R11", "nmi drop", grant, 0);
        expect_none(3, "R11");
        nmi_flag = 1'b0;
        expect_ack(0, "R11");
        master_en = 1'b0;
        step();
        check(grant == '0, "R11", "master drop", grant, 0);
        expect_none(2, "R11");
        master_en = 1'b1;
        expect_ack(0, "R11");
        release_grant("R11");
    endtask

    initial begin
        defaults();
        rst = 1'b1;
        t_reset();
        t_gating();
        t_priority();
        t_source();
        t_normal();
        t_od4();
        t_od8();
        t_nmi();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule